// File: doc/BRIEF.md
# Reset Strap Latch and Reset-Release Sequencer

This block reads a set of board-level configuration straps while the chip reset input is held low. It freezes them at the moment reset is released and holds them until the next chip reset. The frozen values are presented in three forms: a read-only control word with fixed bit positions, decoded configuration outputs, and byte-granular address masks for the two memory windows exposed on the expansion bus. Straps are asynchronous board signals, so each one passes through a synchronizer before it is captured. The value that is kept is the synchronizer output on the last clock edge at which reset is still sampled low.

The block also owns the active-low reset that goes to the rest of the system. A captured strap chooses what releases that reset. In automatic mode, the first PLL lock indication after chip reset releases it. In software mode, a write that sets the release bit of the reset register releases it. Both release conditions are sticky until the next chip reset. A captured PLL multiplier that lies outside its legal range raises a flag, and while that flag is set the system reset is never released. The captured bus-host strap decides whether this device drives the expansion-bus reset line or only receives it.

All inputs are synchronous to `clk`, except the straps, which the block synchronizes itself. The chip reset and the PLL lock input are sampled as synchronous levels.

Top module: `strap_reset_seq`

## Requirements
- R1: The captured strap set equals the strap inputs held for at least three clock cycles before the last clock edge that samples `sys_rst_n` low. After release, strap input changes alter no output until the next chip reset.
- R2: `ctrl_word` carries the captured bus-host strap at bit 31, the boot-from-PROM strap at bit 29 and the bus-boot-host strap at bit 28. All other bits are 0.
- R3: `pci_rst_oe` is 1 when the captured bus-host strap is 1 and 0 when it is 0. `pci_rst_drv_n` always equals `rst_out_n`.
- R4: `rst_out_n` is 0 on every clock edge that samples `sys_rst_n` low.
- R5: In automatic mode (captured auto-release strap = 1), the reset output is released as follows. If `pll_lock` is first sampled high at edge k, `rst_out_n` becomes 1 after edge k+1. It stays 1 when `pll_lock` later drops. Register writes have no effect on it.
- R6: In software mode (auto-release strap = 0), the reset output is released as follows. A write (`sw_wr` = 1) with `sw_wdata[17]` = 1 at edge k makes `rst_out_n` 1 after edge k+1. A write with bit 17 = 0 has no effect, and `pll_lock` has no effect.
- R7: Once released, `rst_out_n` stays 1 until the next chip reset, whatever is written. A chip reset clears the software release, so after it software mode again waits for a new write.
- R8: `mult_invalid` is 1 exactly when the captured 6-bit multiplier is below 16 or above 48. While it is 1, `rst_out_n` stays 0 even if lock is seen or the release bit is written.
- R9: `sram_mask` equals 2^(25+c) - 1, where c is the captured 2-bit SRAM window code (0..3 for 32..256 MB).
- R10: `dram_mask` equals 2^(27+c) - 1, where c is the captured 2-bit DRAM window code (0..3 for 128..1024 MB).
- R11: `txclk_sel_int` equals the captured clock-select strap (1 selects the internal clock, 0 the external reference). `bus_arb_en` equals the captured arbiter strap. `pll_mult_o` equals the captured multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Chip reset, active low, sampled synchronously |
| strap_host_dir | input | 1 | Bus-host strap: 1 = drive the bus reset line |
| strap_prom_boot | input | 1 | Boot-from-PROM strap |
| strap_boot_host | input | 1 | This device configures the expansion bus |
| strap_bus_arb | input | 1 | This device arbitrates the expansion bus |
| strap_auto_release | input | 1 | 1 = release reset on PLL lock, 0 = on software bit |
| strap_txclk_int | input | 1 | Transmit clock select strap |
| strap_sram_win | input | 2 | SRAM window size code |
| strap_dram_win | input | 2 | DRAM window size code |
| strap_pll_mult | input | 6 | PLL multiplier strap |
| pll_lock | input | 1 | PLL lock indication |
| sw_wr | input | 1 | Reset register write strobe |
| sw_wdata | input | 32 | Reset register write data |
| ctrl_word | output | 32 | Read-only control word with captured straps |
| pci_rst_oe | output | 1 | Output enable for the bus reset line |
| pci_rst_drv_n | output | 1 | Value driven onto the bus reset line |
| rst_out_n | output | 1 | System reset output, active low |
| mult_invalid | output | 1 | Captured multiplier out of range |
| pll_mult_o | output | 6 | Captured multiplier |
| sram_mask | output | 30 | SRAM window byte mask |
| dram_mask | output | 30 | DRAM window byte mask |
| txclk_sel_int | output | 1 | Transmit clock source select |
| bus_arb_en | output | 1 | Bus arbiter enable |

## Verification
The bench targets the capture window. Straps are inverted right after release, so a design that keeps sampling after release would show the inverted control word and window masks. It also tests multiplier values on both sides of each range edge (15, 16, 48, 49, 63); an off-by-one compare would flag a legal edge value or release reset on an illegal one. In each release mode it applies the stimulus that belongs to the other mode: software writes in automatic mode, and lock pulses in software mode. It then checks the exact release cycle and the stickiness after lock drops or after a zero write. A second chip reset in software mode catches a release bit that survives reset.

// File: rtl/strap_pkg.sv
package strap_pkg;

   localparam int MULT_W = 6;
   localparam int WIN_W  = 2;

   typedef struct packed {
      logic              host_dir;
      logic              prom_boot;
      logic              boot_host;
      logic              bus_arb;
      logic              auto_release;
      logic              txclk_int;
      logic [WIN_W-1:0]  sram_win;
      logic [WIN_W-1:0]  dram_win;
      logic [MULT_W-1:0] pll_mult;
   } strap_t;

   localparam int STRAP_W = $bits(strap_t);

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("strap_sync: WIDTH must be positive");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("strap_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk;
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             open_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   // Transparent while chip reset is low; frozen from the first high sample.
   always_ff @(posedge clk) begin
      if (!open_n) begin
         q <= d;
      end
   end

endmodule

// File: rtl/mult_check.sv
module mult_check #(
   parameter int W   = 6,
   parameter int MIN = 16,
   parameter int MAX = 48
) (
   input  logic [W-1:0] val,
   output logic         bad
);

   localparam int TOP = (1 << W) - 1;
   localparam logic [W-1:0] MIN_V = W'(MIN);
   localparam logic [W-1:0] MAX_V = W'(MAX);

   if (MIN < 0 || MAX > TOP || MIN > MAX) begin : g_bad_range
      $error("mult_check: range does not fit the field");
   end

   logic below;
   logic above;

   if (MIN == 0) begin : g_no_low
      assign below = 1'b0;
   end else begin : g_low
      assign below = (val < MIN_V);
   end

   if (MAX == TOP) begin : g_no_high
      assign above = 1'b0;
   end else begin : g_high
      assign above = (val > MAX_V);
   end

   assign bad = below | above;

endmodule

// File: rtl/win_decode.sv
module win_decode #(
   parameter int CODE_W    = 2,
   parameter int MASK_W    = 30,
   parameter int BASE_LOG2 = 25
) (
   input  logic [CODE_W-1:0] code,
   output logic [MASK_W-1:0] mask
);

   localparam int MAX_LOG2 = BASE_LOG2 + (1 << CODE_W) - 1;

   if (MAX_LOG2 > MASK_W || BASE_LOG2 < 0) begin : g_bad_mask
      $error("win_decode: largest window does not fit MASK_W");
   end

   // Size is 2^(BASE_LOG2+code) bytes; mask has that many low ones.
   always_comb begin
      for (int i = 0; i < MASK_W; i++) begin
         mask[i] = (i < (BASE_LOG2 + int'(code)));
      end
   end

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic auto_mode,
   input  logic hold_off,
   input  logic pll_lock,
   input  logic rel_write,
   output logic rst_out_n
);

   logic lock_seen;
   logic sw_rel;
   logic go;

   always_ff @(posedge clk) begin
      if (!sys_rst_n) begin
         lock_seen <= 1'b0;
         sw_rel    <= 1'b0;
      end else begin
         lock_seen <= lock_seen | pll_lock;
         sw_rel    <= sw_rel | rel_write;
      end
   end

   assign go = auto_mode ? lock_seen : sw_rel;

   always_ff @(posedge clk) begin
      if (!sys_rst_n) begin
         rst_out_n <= 1'b0;
      end else begin
         rst_out_n <= rst_out_n | (go & ~hold_off);
      end
   end

endmodule

// File: rtl/strap_reset_seq.sv
module strap_reset_seq
   import strap_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int REG_W          = 32,
   parameter int REL_BIT        = 17,
   parameter int CTRL_W         = 32,
   parameter int DIR_BIT        = 31,
   parameter int PROM_BIT       = 29,
   parameter int BHOST_BIT      = 28,
   parameter int MULT_MIN       = 16,
   parameter int MULT_MAX       = 48,
   parameter int MASK_W         = 30,
   parameter int SRAM_BASE_LOG2 = 25,
   parameter int DRAM_BASE_LOG2 = 27
) (
   input  logic              clk,
   input  logic              sys_rst_n,
   input  logic              strap_host_dir,
   input  logic              strap_prom_boot,
   input  logic              strap_boot_host,
   input  logic              strap_bus_arb,
   input  logic              strap_auto_release,
   input  logic              strap_txclk_int,
   input  logic [WIN_W-1:0]  strap_sram_win,
   input  logic [WIN_W-1:0]  strap_dram_win,
   input  logic [MULT_W-1:0] strap_pll_mult,
   input  logic              pll_lock,
   input  logic              sw_wr,
   input  logic [REG_W-1:0]  sw_wdata,
   output logic [CTRL_W-1:0] ctrl_word,
   output logic              pci_rst_oe,
   output logic              pci_rst_drv_n,
   output logic              rst_out_n,
   output logic              mult_invalid,
   output logic [MULT_W-1:0] pll_mult_o,
   output logic [MASK_W-1:0] sram_mask,
   output logic [MASK_W-1:0] dram_mask,
   output logic              txclk_sel_int,
   output logic              bus_arb_en
);

   if (REL_BIT >= REG_W || REL_BIT < 0) begin : g_bad_rel
      $error("strap_reset_seq: REL_BIT outside register");
   end
   if (DIR_BIT >= CTRL_W || PROM_BIT >= CTRL_W || BHOST_BIT >= CTRL_W ||
       DIR_BIT == PROM_BIT || DIR_BIT == BHOST_BIT || PROM_BIT == BHOST_BIT) begin : g_bad_ctrl
      $error("strap_reset_seq: control bit positions overlap or overflow");
   end

   strap_t raw;
   strap_t synced;
   strap_t latched;
   logic   auto_mode_q;
   logic   rel_write;
   logic   unused_wdata;

   always_comb begin
      raw.host_dir     = strap_host_dir;
      raw.prom_boot    = strap_prom_boot;
      raw.boot_host    = strap_boot_host;
      raw.bus_arb      = strap_bus_arb;
      raw.auto_release = strap_auto_release;
      raw.txclk_int    = strap_txclk_int;
      raw.sram_win     = strap_sram_win;
      raw.dram_win     = strap_dram_win;
      raw.pll_mult     = strap_pll_mult;
   end

   strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (raw),
      .q   (synced)
   );

   strap_capture #(.WIDTH(STRAP_W)) u_cap (
      .clk    (clk),
      .open_n (sys_rst_n),
      .d      (synced),
      .q      (latched)
   );

   mult_check #(.W(MULT_W), .MIN(MULT_MIN), .MAX(MULT_MAX)) u_mult (
      .val (latched.pll_mult),
      .bad (mult_invalid)
   );

   win_decode #(.CODE_W(WIN_W), .MASK_W(MASK_W), .BASE_LOG2(SRAM_BASE_LOG2)) u_sram_win (
      .code (latched.sram_win),
      .mask (sram_mask)
   );

   win_decode #(.CODE_W(WIN_W), .MASK_W(MASK_W), .BASE_LOG2(DRAM_BASE_LOG2)) u_dram_win (
      .code (latched.dram_win),
      .mask (dram_mask)
   );

   assign auto_mode_q  = latched.auto_release;
   assign rel_write    = sw_wr & sw_wdata[REL_BIT];
   assign unused_wdata = ^sw_wdata;

   rst_release_seq u_rel (
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .auto_mode (auto_mode_q),
      .hold_off  (mult_invalid),
      .pll_lock  (pll_lock),
      .rel_write (rel_write),
      .rst_out_n (rst_out_n)
   );

   always_comb begin
      ctrl_word            = '0;
      ctrl_word[DIR_BIT]   = latched.host_dir;
      ctrl_word[PROM_BIT]  = latched.prom_boot;
      ctrl_word[BHOST_BIT] = latched.boot_host;
   end

   assign pci_rst_oe    = latched.host_dir;
   assign pci_rst_drv_n = rst_out_n;
   assign pll_mult_o    = latched.pll_mult;
   assign txclk_sel_int = latched.txclk_int;
   assign bus_arb_en    = latched.bus_arb;

endmodule

// File: rtl/strap_reset_chk.sv
module strap_reset_chk #(
   parameter int REG_W   = 32,
   parameter int REL_BIT = 17,
   parameter int CTRL_W  = 32,
   parameter int MASK_W  = 30
) (
   input logic              clk,
   input logic              sys_rst_n,
   input logic              pll_lock,
   input logic              sw_wr,
   input logic [REG_W-1:0]  sw_wdata,
   input logic              auto_mode_q,
   input logic              mult_invalid,
   input logic              rst_out_n,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [MASK_W-1:0] sram_mask,
   input logic [MASK_W-1:0] dram_mask
);

   assert_hold_after_release_R1: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $past(sys_rst_n) |-> ($stable(ctrl_word) && $stable(sram_mask) && $stable(dram_mask)));

   assert_auto_release_cause_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ($rose(rst_out_n) && auto_mode_q) |-> $past(pll_lock, 2));

   assert_sw_release_cause_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ($rose(rst_out_n) && !auto_mode_q) |-> $past(sw_wr && sw_wdata[REL_BIT], 2));

   assert_release_sticky_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
      rst_out_n |=> rst_out_n);

   assert_invalid_blocks_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      mult_invalid |-> !rst_out_n);

endmodule

bind strap_reset_seq strap_reset_chk #(
   .REG_W   (REG_W),
   .REL_BIT (REL_BIT),
   .CTRL_W  (CTRL_W),
   .MASK_W  (MASK_W)
) u_chk (
   .clk          (clk),
   .sys_rst_n    (sys_rst_n),
   .pll_lock     (pll_lock),
   .sw_wr        (sw_wr),
   .sw_wdata     (sw_wdata),
   .auto_mode_q  (auto_mode_q),
   .mult_invalid (mult_invalid),
   .rst_out_n    (rst_out_n),
   .ctrl_word    (ctrl_word),
   .sram_mask    (sram_mask),
   .dram_mask    (dram_mask)
);

// File: tb/tb_strap_reset_seq.sv
`timescale 1ns/100ps
module tb_strap_reset_seq;

   logic        clk = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        s_dir = 1'b0, s_prom = 1'b0, s_bh = 1'b0, s_arb = 1'b0;
   logic        s_auto = 1'b0, s_tx = 1'b0;
   logic [1:0]  s_sw = 2'd0, s_dw = 2'd0;
   logic [5:0]  s_mult = 6'd16;
   logic        pll_lock = 1'b0;
   logic        sw_wr = 1'b0;
   logic [31:0] sw_wdata = 32'd0;

   logic [31:0] ctrl_word;
   logic        pci_rst_oe, pci_rst_drv_n, rst_out_n, mult_invalid;
   logic [5:0]  pll_mult_o;
   logic [29:0] sram_mask, dram_mask;
   logic        txclk_sel_int, bus_arb_en;

   always #2.5 clk = ~clk;

   strap_reset_seq dut (
      .clk (clk), .sys_rst_n (sys_rst_n),
      .strap_host_dir (s_dir), .strap_prom_boot (s_prom), .strap_boot_host (s_bh),
      .strap_bus_arb (s_arb), .strap_auto_release (s_auto), .strap_txclk_int (s_tx),
      .strap_sram_win (s_sw), .strap_dram_win (s_dw), .strap_pll_mult (s_mult),
      .pll_lock (pll_lock), .sw_wr (sw_wr), .sw_wdata (sw_wdata),
      .ctrl_word (ctrl_word), .pci_rst_oe (pci_rst_oe), .pci_rst_drv_n (pci_rst_drv_n),
      .rst_out_n (rst_out_n), .mult_invalid (mult_invalid), .pll_mult_o (pll_mult_o),
      .sram_mask (sram_mask), .dram_mask (dram_mask),
      .txclk_sel_int (txclk_sel_int), .bus_arb_en (bus_arb_en)
   );

   typedef enum int {
      O_CTRL, O_OE, O_RST, O_INV, O_MULT, O_SRAM, O_DRAM, O_TX, O_ARB, O_DRV
   } obs_e;

   typedef struct {
      string       req;
      obs_e        sel;
      logic [63:0] exp;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   function automatic logic [63:0] observe(obs_e s);
      case (s)
         O_CTRL:  return 64'(ctrl_word);
         O_OE:    return 64'(pci_rst_oe);
         O_RST:   return 64'(rst_out_n);
         O_INV:   return 64'(mult_invalid);
         O_MULT:  return 64'(pll_mult_o);
         O_SRAM:  return 64'(sram_mask);
         O_DRAM:  return 64'(dram_mask);
         O_TX:    return 64'(txclk_sel_int);
         O_ARB:   return 64'(bus_arb_en);
         default: return 64'(pci_rst_drv_n);
      endcase
   endfunction

   // Monitor: compare every queued expectation at the falling edge.
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [63:0] got;
         it  = q.pop_front();
         got = observe(it.sel);
         checks++;
         if (got !== it.exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", it.req, it.sel.name(), got, it.exp);
         end
      end
   end

   task automatic expect_val(string req, obs_e sel, logic [63:0] exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic set_straps(logic dir, logic prom, logic bh, logic arb, logic au,
                             logic tx, logic [1:0] sw, logic [1:0] dw, logic [5:0] m);
      s_dir = dir; s_prom = prom; s_bh = bh; s_arb = arb; s_auto = au;
      s_tx = tx; s_sw = sw; s_dw = dw; s_mult = m;
   endtask

   task automatic scramble_straps();
      s_dir = ~s_dir; s_prom = ~s_prom; s_bh = ~s_bh; s_arb = ~s_arb;
      s_auto = ~s_auto; s_tx = ~s_tx; s_sw = ~s_sw; s_dw = ~s_dw; s_mult = ~s_mult;
   endtask

   task automatic chip_reset();
      sys_rst_n = 1'b0;
      ticks(6);
      expect_val("R4", O_RST, 64'd0);
      expect_val("R3", O_DRV, 64'd0);
      ticks(1);
      sys_rst_n = 1'b1;
      tick();
   endtask

   task automatic reg_write(logic [31:0] data);
      sw_wr = 1'b1; sw_wdata = data;
      tick();
      sw_wr = 1'b0; sw_wdata = 32'd0;
   endtask

   function automatic logic [63:0] ctrl_exp(logic dir, logic prom, logic bh);
      return (64'(dir) << 31) | (64'(prom) << 29) | (64'(bh) << 28);
   endfunction

   function automatic logic [63:0] win_mask(int base, logic [1:0] c);
      return (64'd1 << (base + int'(c))) - 64'd1;
   endfunction

   task automatic check_capture(logic dir, logic prom, logic bh, logic arb, logic tx,
                                logic [1:0] sw, logic [1:0] dw, logic [5:0] m);
      expect_val("R2", O_CTRL, ctrl_exp(dir, prom, bh));
      expect_val("R3", O_OE, 64'(dir));
      expect_val("R9", O_SRAM, win_mask(25, sw));
      expect_val("R10", O_DRAM, win_mask(27, dw));
      expect_val("R11", O_TX, 64'(tx));
      expect_val("R11", O_ARB, 64'(arb));
      expect_val("R11", O_MULT, 64'(m));
   endtask

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            if (!done) begin
               fails++;
               $display("FAIL watchdog: got timeout expected completion");
               $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
               $finish;
            end
         end
      join_none

      // Run A: automatic release, host mode
      set_straps(1, 1, 0, 1, 1, 1, 2'd2, 2'd1, 6'd20);
      chip_reset();
      check_capture(1, 1, 0, 1, 1, 2'd2, 2'd1, 6'd20);
      expect_val("R8", O_INV, 64'd0);
      expect_val("R4", O_RST, 64'd0);
      scramble_straps();
      ticks(4);
      // R1: inverted straps after release must not change anything
      expect_val("R1", O_CTRL, ctrl_exp(1, 1, 0));
      expect_val("R1", O_SRAM, win_mask(25, 2'd2));
      expect_val("R1", O_DRAM, win_mask(27, 2'd1));
      expect_val("R1", O_MULT, 64'd20);
      reg_write(32'h0002_0000);
      ticks(2);
      expect_val("R5", O_RST, 64'd0);
      pll_lock = 1'b1;
      tick();
      expect_val("R5", O_RST, 64'd0);
      tick();
      expect_val("R5", O_RST, 64'd1);
      expect_val("R3", O_DRV, 64'd1);
      pll_lock = 1'b0;
      ticks(3);
      expect_val("R5", O_RST, 64'd1);

      // Run B: software release, device mode, multiplier at top of range
      set_straps(0, 0, 1, 0, 0, 0, 2'd0, 2'd3, 6'd48);
      chip_reset();
      check_capture(0, 0, 1, 0, 0, 2'd0, 2'd3, 6'd48);
      expect_val("R8", O_INV, 64'd0);
      expect_val("R7", O_RST, 64'd0);
      pll_lock = 1'b1;
      ticks(3);
      expect_val("R6", O_RST, 64'd0);
      pll_lock = 1'b0;
      reg_write(32'hFFFD_FFFF);
      ticks(2);
      expect_val("R6", O_RST, 64'd0);
      reg_write(32'h0002_0000);
      expect_val("R6", O_RST, 64'd0);
      tick();
      expect_val("R6", O_RST, 64'd1);
      reg_write(32'h0000_0000);
      ticks(2);
      expect_val("R7", O_RST, 64'd1);

      // Run C: software mode again, chip reset must clear the release
      set_straps(1, 0, 0, 1, 0, 1, 2'd1, 2'd2, 6'd16);
      chip_reset();
      check_capture(1, 0, 0, 1, 1, 2'd1, 2'd2, 6'd16);
      expect_val("R8", O_INV, 64'd0);
      ticks(3);
      expect_val("R7", O_RST, 64'd0);

      // Run D: multiplier below range, automatic mode with lock
      set_straps(0, 1, 1, 0, 1, 0, 2'd3, 2'd0, 6'd15);
      chip_reset();
      check_capture(0, 1, 1, 0, 0, 2'd3, 2'd0, 6'd15);
      expect_val("R8", O_INV, 64'd1);
      pll_lock = 1'b1;
      ticks(4);
      expect_val("R8", O_RST, 64'd0);
      pll_lock = 1'b0;

      // Run E: multiplier above range, software mode with release write
      set_straps(0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 6'd49);
      chip_reset();
      expect_val("R8", O_INV, 64'd1);
      reg_write(32'h0002_0000);
      ticks(3);
      expect_val("R8", O_RST, 64'd0);

      // Run F: all-ones multiplier
      set_straps(0, 0, 0, 0, 1, 0, 2'd0, 2'd0, 6'd63);
      chip_reset();
      expect_val("R8", O_INV, 64'd1);

      tick();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule